// File: doc/BRIEF.md
# Trim Register Refresh Controller

This block keeps a set of analog trim settings (one configuration word and four DAC words) in step with the contents of a nonvolatile store. It copies all five words out of the store through a simple synchronous read port, one word per cycle, in a fixed order. The read data appears one cycle after the request.

A copy pass starts for one of three reasons:
- once after reset;
- on a chip-select rising edge, unless the serial interface last latched an update-inhibit flag of 1;
- periodically, while the write-enable pin is high and no serial session is open.

A trigger that arrives while a pass is already running joins that pass. The same pin also grants permission for erase and write operations to the store.

The serial interface drives `cs_rise` for one cycle on each chip-select rising edge. It drives `inh_load` together with `inh_val` when it decodes a new inhibit flag, and it holds `session_active` high while it is accepting control words. The periodic interval is the parameter `REFRESH_CYCLES`, counted in system clock cycles. At 1 MHz, 2500 cycles gives 400 refreshes per second.

Top module: `trim_refresh_ctrl`

## Requirements
- R1: After reset is released, one copy pass runs without any other stimulus and loads all five trim registers from the store. While in reset, `busy` is 0, every trim register is 0 and `erase_write_ok` is 0.
- R2: A pass reads store addresses `BASE_ADDR`+0 to `BASE_ADDR`+4 in rising order. The configuration word is at offset 0 and DAC k is at offset k+1. `busy` is high for exactly six consecutive cycles per pass.
- R3: A `cs_rise` pulse while the inhibit flag is 0 starts a pass, and afterwards the trim registers hold the current store contents.
- R4: A `cs_rise` pulse while the inhibit flag is 1 starts no pass, and the trim registers keep their values.
- R5: The inhibit flag is 0 after reset and takes `inh_val` on each cycle with `inh_load` high. A `cs_rise` in the same cycle as a load is judged by the flag value from before that load.
- R6: While `wr_en_pin` is high and `session_active` is low, a pass starts every `REFRESH_CYCLES` cycles. The first one starts `REFRESH_CYCLES` cycles after the enable begins.
- R7: While `wr_en_pin` is low, no periodic pass starts.
- R8: While `session_active` is high, no periodic pass starts, and the interval count starts over once the session ends.
- R9: `erase_write_ok` equals `wr_en_pin`.
- R10: A trigger that arrives while `busy` is high starts no second pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en_pin | input | 1 | Write-enable pin level |
| cs_rise | input | 1 | One-cycle pulse on a chip-select rising edge |
| session_active | input | 1 | High while a serial session is open |
| inh_load | input | 1 | Strobe to latch a new inhibit flag |
| inh_val | input | 1 | Inhibit flag value to latch |
| mem_rd_en | output | 1 | Store read request |
| mem_addr | output | ADDR_W | Store read address |
| mem_rd_data | input | DATA_W | Store read data, one cycle after request |
| erase_write_ok | output | 1 | Erase/write permission |
| busy | output | 1 | High during a copy pass |
| cfg_reg | output | DATA_W | Configuration trim register |
| dac_regs | output | NUM_DAC*DATA_W | DAC trim registers, DAC0 in the low bits |

## Verification
Two functions can fall in the same cycle. The first case is a chip-select edge that coincides with a new inhibit-flag load. The bench provokes it by raising `cs_rise` and `inh_load` in the same cycle, with the stored flag and the incoming value set opposite. It judges the result by whether a pass starts and whether changed store contents reach the trim registers. The second case is a trigger that lands inside a running pass. The bench raises a second chip-select pulse two cycles after the first. It then counts `busy` rising edges and measures the pulse length to confirm that exactly one six-cycle pass occurred.

// File: rtl/trim_pkg.sv
package trim_pkg;

  // The interval counter has reached its last cycle.
  function automatic logic period_done(input int unsigned cnt, input int unsigned period);
    return cnt == period - 1;
  endfunction

  // Store address of the register at position idx within a pass.
  function automatic int unsigned word_addr(input int unsigned base, input int unsigned idx);
    return base + idx;
  endfunction

  // Position idx is the final register of a pass.
  function automatic logic is_last(input int unsigned idx, input int unsigned nregs);
    return idx == nregs - 1;
  endfunction

endpackage

// File: rtl/trim_refresh_timer.sv
module trim_refresh_timer #(
  parameter int PERIOD = 2500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CNT_W = $clog2(PERIOD + 1);

  logic [CNT_W-1:0] cnt_q;

  assign tick = run && trim_pkg::period_done(32'(cnt_q), PERIOD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!run)   cnt_q <= '0;
    else if (tick)   cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  // A tick always restarts the interval.
  assert_tick_restarts_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> cnt_q == '0);

  // A stopped timer resumes from zero.
  assert_stop_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !tick || PERIOD == 1);

endmodule

// File: rtl/trim_reload_seq.sv
module trim_reload_seq #(
  parameter int DATA_W    = 8,
  parameter int NUM_REGS  = 5,
  parameter int ADDR_W    = 4,
  parameter int BASE_ADDR = 0
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  output logic                        busy,
  output logic                        rd_en,
  output logic [ADDR_W-1:0]           rd_addr,
  input  logic [DATA_W-1:0]           rd_data,
  output logic                        wr_vld,
  output logic [$clog2(NUM_REGS+1)-1:0] wr_idx,
  output logic [DATA_W-1:0]           wr_data
);
  localparam int IDX_W = $clog2(NUM_REGS + 1);

  logic             busy_q;
  logic [IDX_W-1:0] iss_q;
  logic             cap_vld_q;
  logic [IDX_W-1:0] cap_idx_q;
  logic             pass_end;

  assign busy     = busy_q;
  assign rd_en    = busy_q && (iss_q < IDX_W'(NUM_REGS));
  assign rd_addr  = ADDR_W'(trim_pkg::word_addr(BASE_ADDR, 32'(iss_q)));
  assign wr_vld   = cap_vld_q;
  assign wr_idx   = cap_idx_q;
  assign wr_data  = rd_data;
  assign pass_end = cap_vld_q && trim_pkg::is_last(32'(cap_idx_q), NUM_REGS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      iss_q     <= '0;
      cap_vld_q <= 1'b0;
      cap_idx_q <= '0;
    end else begin
      cap_vld_q <= rd_en;
      cap_idx_q <= iss_q;
      if (start && !busy_q) begin
        busy_q <= 1'b1;
        iss_q  <= '0;
      end else begin
        if (rd_en)    iss_q  <= iss_q + 1'b1;
        if (pass_end) busy_q <= 1'b0;
      end
    end
  end

  // Captured words arrive in strictly rising register order.
  assert_capture_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cap_vld_q && $past(cap_vld_q) |-> cap_idx_q == $past(cap_idx_q) + 1'b1);

  // Reads only happen inside a pass.
  assert_read_in_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> busy_q);

  // A pass ends only after the last register was captured.
  assert_pass_complete_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> $past(cap_vld_q) && $past(cap_idx_q) == IDX_W'(NUM_REGS - 1));

endmodule

// File: rtl/trim_regbank.sv
module trim_regbank #(
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 5
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_vld,
  input  logic [$clog2(NUM_REGS+1)-1:0] wr_idx,
  input  logic [DATA_W-1:0]             wr_data,
  output logic [NUM_REGS*DATA_W-1:0]    regs_flat
);
  localparam int IDX_W = $clog2(NUM_REGS + 1);

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
    logic [DATA_W-1:0] val_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  val_q <= '0;
      else if (wr_vld && wr_idx == IDX_W'(k))      val_q <= wr_data;
    end
    assign regs_flat[k*DATA_W +: DATA_W] = val_q;
  end

endmodule

// File: rtl/trim_refresh_ctrl.sv
module trim_refresh_ctrl #(
  parameter int DATA_W         = 8,
  parameter int NUM_DAC        = 4,
  parameter int ADDR_W         = 4,
  parameter int BASE_ADDR      = 0,
  parameter int REFRESH_CYCLES = 2500
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en_pin,
  input  logic                      cs_rise,
  input  logic                      session_active,
  input  logic                      inh_load,
  input  logic                      inh_val,
  output logic                      mem_rd_en,
  output logic [ADDR_W-1:0]         mem_addr,
  input  logic [DATA_W-1:0]         mem_rd_data,
  output logic                      erase_write_ok,
  output logic                      busy,
  output logic [DATA_W-1:0]         cfg_reg,
  output logic [NUM_DAC*DATA_W-1:0] dac_regs
);
  localparam int NUM_REGS = NUM_DAC + 1;
  localparam int IDX_W    = $clog2(NUM_REGS + 1);

  logic                       pwr_req_q;
  logic                       inhibit_q;
  logic                       cs_req;
  logic                       tick;
  logic                       timer_run;
  logic                       trig;
  logic                       start;
  logic                       wr_vld;
  logic [IDX_W-1:0]           wr_idx;
  logic [DATA_W-1:0]          wr_data;
  logic [NUM_REGS*DATA_W-1:0] regs_flat;

  assign erase_write_ok = wr_en_pin;
  assign timer_run      = wr_en_pin && !session_active;
  assign cs_req         = cs_rise && !inhibit_q;
  assign trig           = pwr_req_q || cs_req || tick;
  assign start          = trig && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_req_q <= 1'b1;
      inhibit_q <= 1'b0;
    end else begin
      if (start)    pwr_req_q <= 1'b0;
      if (inh_load) inhibit_q <= inh_val;
    end
  end

  trim_refresh_timer #(.PERIOD(REFRESH_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(timer_run), .tick(tick)
  );

  trim_reload_seq #(
    .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
    .rd_en(mem_rd_en), .rd_addr(mem_addr), .rd_data(mem_rd_data),
    .wr_vld(wr_vld), .wr_idx(wr_idx), .wr_data(wr_data)
  );

  trim_regbank #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_vld(wr_vld), .wr_idx(wr_idx),
    .wr_data(wr_data), .regs_flat(regs_flat)
  );

  assign cfg_reg  = regs_flat[DATA_W-1:0];
  assign dac_regs = regs_flat[NUM_REGS*DATA_W-1:DATA_W];

  // Every pass has a cause in the cycle before it starts.
  assert_pass_has_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(trig));

  // An inhibited chip-select edge with no other cause starts nothing.
  assert_inhibit_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise && inhibit_q && !pwr_req_q && !tick && !busy |=> !busy);

  // The power-up request is consumed by a pass that begins at once.
  assert_powerup_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_req_q) |-> busy);

  // A flag load changes the flag seen on the following cycle.
  assert_flag_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    inh_load |=> inhibit_q == $past(inh_val));

endmodule

// File: tb/trim_refresh_ctrl_bench.sv
module trim_refresh_ctrl_bench;
  localparam int DW = 8;
  localparam int ND = 4;
  localparam int AW = 4;
  localparam int P  = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en_pin = 1'b0, cs_rise = 1'b0, session_active = 1'b0;
  logic inh_load = 1'b0, inh_val = 1'b0;
  logic mem_rd_en, erase_write_ok, busy;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_rd_data = '0;
  logic [DW-1:0] cfg_reg;
  logic [ND*DW-1:0] dac_regs;

  logic [DW-1:0] mem [0:15];

  int checks = 0, fails = 0;
  int starts = 0, cur_len = 0, last_len = 0, log_n = 0;
  logic [AW-1:0] addr_log [0:15];
  logic prev_busy = 1'b0;

  always #10 clk = ~clk;

  trim_refresh_ctrl #(.DATA_W(DW), .NUM_DAC(ND), .ADDR_W(AW), .BASE_ADDR(0),
                      .REFRESH_CYCLES(P)) u_trim_refresh_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en_pin(wr_en_pin), .cs_rise(cs_rise),
    .session_active(session_active), .inh_load(inh_load), .inh_val(inh_val),
    .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rd_data(mem_rd_data),
    .erase_write_ok(erase_write_ok), .busy(busy), .cfg_reg(cfg_reg), .dac_regs(dac_regs)
  );

  // Store model: synchronous read, one-cycle latency.
  always @(posedge clk) if (mem_rd_en) mem_rd_data <= mem[mem_addr];

  // Pass monitor.
  always @(posedge clk) begin
    prev_busy <= busy;
    if (busy && !prev_busy) starts <= starts + 1;
    if (busy) cur_len <= (prev_busy ? cur_len : 0) + 1;
    if (!busy && prev_busy) last_len <= cur_len;
    if (mem_rd_en && log_n < 16) begin
      addr_log[log_n] <= mem_addr;
      log_n <= log_n + 1;
    end
  end

  task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [ND*DW-1:0] exp_dacs();
    logic [ND*DW-1:0] v;
    for (int k = 0; k < ND; k++) v[k*DW +: DW] = mem[k+1];
    return v;
  endfunction

  task automatic fill(input logic [DW-1:0] seed);
    for (int k = 0; k < 5; k++) mem[k] = seed + DW'(k * 17);
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_cs();
    cs_rise = 1'b1; cycles(1); cs_rise = 1'b0;
  endtask

  task automatic set_flag(input logic v);
    inh_load = 1'b1; inh_val = v; cycles(1); inh_load = 1'b0;
  endtask

  task automatic check_loaded(input string req);
    check(cfg_reg == mem[0], req, 64'(cfg_reg), 64'(mem[0]));
    check(dac_regs == exp_dacs(), req, 64'(dac_regs), 64'(exp_dacs()));
  endtask

  task automatic t_reset();
    fill(8'h10);
    cycles(2);
    check(busy == 0 && cfg_reg == 0 && dac_regs == 0 && erase_write_ok == 0,
          "R1 reset state", {busy, erase_write_ok, cfg_reg}, 64'd0);
  endtask

  task automatic t_powerup();
    log_n = 0;
    rst_n = 1'b1;
    cycles(10);
    check_loaded("R1 power-up load");
    check(starts == 1, "R1 single pass", 64'(starts), 64'd1);
    check(last_len == 6, "R2 busy length", 64'(last_len), 64'd6);
    for (int k = 0; k < 5; k++)
      check(addr_log[k] == AW'(k), "R2 address order", 64'(addr_log[k]), 64'(k));
    check(log_n == 5, "R2 read count", 64'(log_n), 64'd5);
  endtask

  task automatic t_cs_reload();
    int s0 = starts;
    fill(8'h30);
    pulse_cs(); cycles(8);
    check_loaded("R3 cs reload");
    check(starts == s0 + 1, "R3 pass started", 64'(starts), 64'(s0 + 1));
  endtask

  task automatic t_inhibit();
    int s0;
    logic [DW-1:0] c0 = cfg_reg;
    set_flag(1'b1);
    s0 = starts;
    fill(8'h50);
    pulse_cs(); cycles(8);
    check(cfg_reg == c0, "R4 inhibited cs keeps cfg", 64'(cfg_reg), 64'(c0));
    check(starts == s0, "R4 no pass", 64'(starts), 64'(s0));
  endtask

  task automatic t_same_cycle();
    int s0 = starts;
    logic [DW-1:0] c0 = cfg_reg;
    // Flag is 1; load 0 in the same cycle as cs_rise: old flag rules.
    cs_rise = 1'b1; inh_load = 1'b1; inh_val = 1'b0;
    cycles(1);
    cs_rise = 1'b0; inh_load = 1'b0;
    cycles(8);
    check(cfg_reg == c0 && starts == s0, "R5 old flag governs", 64'(starts), 64'(s0));
    pulse_cs(); cycles(8);
    check_loaded("R5 new flag 0 allows reload");
  endtask

  task automatic t_merge();
    int s0 = starts;
    pulse_cs(); cycles(1);
    fill(8'h70);
    pulse_cs(); cycles(10);
    check(starts == s0 + 1, "R10 merged trigger", 64'(starts), 64'(s0 + 1));
    check(last_len == 6, "R10 single pass length", 64'(last_len), 64'd6);
  endtask

  task automatic t_wr_low();
    int s0 = starts;
    logic [DW-1:0] c0 = cfg_reg;
    fill(8'h90);
    cycles(3 * P);
    check(erase_write_ok == 0, "R9 permission low", 64'(erase_write_ok), 64'd0);
    check(starts == s0 && cfg_reg == c0, "R7 no refresh when pin low", 64'(starts), 64'(s0));
  endtask

  task automatic t_periodic();
    int s0 = starts;
    wr_en_pin = 1'b1;
    cycles(1);
    check(erase_write_ok == 1, "R9 permission high", 64'(erase_write_ok), 64'd1);
    cycles(P - 3);
    check(starts == s0, "R6 not before interval", 64'(starts), 64'(s0));
    cycles(2 * P + 5);
    check(starts == s0 + 3, "R6 three periodic passes", 64'(starts), 64'(s0 + 3));
    check_loaded("R6 periodic load");
  endtask

  task automatic t_session();
    int s0;
    logic [DW-1:0] c0;
    session_active = 1'b1;
    cycles(8);
    s0 = starts; c0 = cfg_reg;
    fill(8'hB0);
    cycles(4 * P);
    check(starts == s0 && cfg_reg == c0, "R8 session suppresses", 64'(starts), 64'(s0));
    session_active = 1'b0;
    cycles(P - 3);
    check(starts == s0, "R8 count restarts", 64'(starts), 64'(s0));
    cycles(10);
    check(starts == s0 + 1, "R8 refresh after session", 64'(starts), 64'(s0 + 1));
    wr_en_pin = 1'b0;
  endtask

  initial begin
    t_reset();
    t_powerup();
    t_cs_reload();
    t_inhibit();
    t_same_cycle();
    t_merge();
    t_wr_low();
    t_periodic();
    t_session();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule